// File: doc/BRIEF.md
# Multiplexed Host-Bus Master with Programmable Wait States

This block is a synchronous master for an external parallel host bus whose address and data share the same lines. An internal client hands it one read or write at a time over a valid/ready request port. The block then runs one bus cycle. The cycle starts with an address phase, in which the address drives the shared lines and an address-latch strobe tells an external latch to capture it. A data phase follows, marked by a read or a write strobe, and a programmable idle gap comes last before the next request is taken. Read data returns on a one-cycle response pulse.

The data-phase length uses a split encoding: a 2-bit coarse field and a 1-bit fine bit, set separately for reads and writes, give 1 to 8 clocks. A combined chip-select code chooses the pin arrangement: the latch strobe alone, the strobe plus two chip selects, or the strobe plus four chip selects. The chip select is picked from the top address bits. The data phase can use 16 bits or only the low byte. A burst-enable bit is accepted only so that the block can detect an illegal mix. When that bit is set together with nonzero wait settings, the block raises a configuration error and ignores the wait settings.

Configuration inputs are assumed stable from the acceptance of a request until the block is ready again.

Top module: `hbus_mux_master`

## Requirements
- R1: `bus_ale` is high for exactly one clock, which is the first clock after a request is accepted. During that clock `bus_oe` is 1 and `bus_out` carries the full request address.
- R2: The data phase is the run of clocks with `bus_rd_n` low (reads) or `bus_wr_n` low (writes). It lasts 2*coarse+1 clocks when the fine bit is 1 and 2*coarse+2 clocks when the fine bit is 0. Reads use `cfg_rd_coarse`/`cfg_rd_fine` and writes use `cfg_wr_coarse`/`cfg_wr_fine`.
- R3: If `cfg_burst` is 1 and any wait-setting bit is nonzero, `cfg_err` is 1 and every data phase lasts 2 clocks. Otherwise `cfg_err` is 0.
- R4: The chip-select code {`cfg_cs_ext`,`cfg_cs_field`} selects the arrangement. Code 0/0 drives no chip select. Code 0/3 uses `bus_cs_n[1:0]`, indexed by address bit 15. Code 1/0 uses `bus_cs_n[3:0]`, indexed by address bits 15:14. Every other code behaves like 0/0.
- R5: The selected chip-select line is low from the address phase through the last data clock. All chip-select lines are high at every other time, and at most one is low.
- R6: After the last data clock, `req_ready` stays low for exactly G clocks and then goes high. G equals `cfg_gap`.
- R7: G is `cfg_gap`+1 when `cfg_cs_clk` is 1 and the code selects two or four chip selects.
- R8: In a read data phase `bus_oe` is 0. `rsp_rdata` returns the bus value sampled on the last data clock. `rsp_valid` is high for exactly the one clock after the data phase.
- R9: In a write data phase `bus_oe` is 1, `bus_out` carries the write data, and `bus_rd_n` stays high. No `rsp_valid` pulse is produced for a write.
- R10: With `cfg_wide`=1 all 16 data bits are used. With `cfg_wide`=0 only bits 7:0 are used: the upper write byte is driven as 0 and the upper read byte returns 0.
- R11: After reset, and whenever the block is idle, `req_ready` is 1. In that state `bus_ale`, `bus_oe` and `rsp_valid` are 0, and both strobes and all chip selects are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wide | input | 1 | 1 = 16-bit data, 0 = 8-bit data |
| cfg_rd_coarse | input | 2 | Read wait coarse field |
| cfg_rd_fine | input | 1 | Read wait fine bit |
| cfg_wr_coarse | input | 2 | Write wait coarse field |
| cfg_wr_fine | input | 1 | Write wait fine bit |
| cfg_burst | input | 1 | Burst-enable bit, used only for the legality check |
| cfg_cs_field | input | 2 | Chip-select arrangement field |
| cfg_cs_ext | input | 1 | Chip-select arrangement extension bit |
| cfg_cs_clk | input | 1 | Per-chip-select clocking enable (adds one gap clock) |
| cfg_gap | input | GAP_W | Idle clocks between transfers |
| cfg_err | output | 1 | Illegal burst plus wait-state combination |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high with valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | BUS_W | Request address |
| req_wdata | input | BUS_W | Write data |
| rsp_valid | output | 1 | One-cycle read-data pulse |
| rsp_rdata | output | BUS_W | Read data |
| bus_ale | output | 1 | Address-latch strobe |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_wr_n | output | 1 | Write strobe, active low |
| bus_cs_n | output | 4 | Chip selects, active low |
| bus_out | output | BUS_W | Shared lines, driven value |
| bus_oe | output | 1 | Shared lines output enable |
| bus_in | input | BUS_W | Shared lines, sampled value |

## Verification
The bench uses the default BUS_W=16 and GAP_W=4. With these values both data widths can be exercised on one instance, both address bits that pick a chip select are reachable, and gaps from 0 to 16 clocks, including the extra clock, can be produced. A bench-side device model answers each read with a pattern derived from the latched address. The 16-clock gap at GAP_W=4 also exercises the widened counter.

// File: rtl/hbus_pkg.sv
// Shared types and helpers for the multiplexed host-bus master.
// Assumes nothing beyond IEEE 1800-2017 packages.
package hbus_pkg;

    // Sequencer phases of one bus transfer
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ADDR = 2'd1,
        ST_DATA = 2'd2,
        ST_GAP  = 2'd3
    } hb_state_t;

    // Chip-select pin arrangements
    typedef enum logic [1:0] {
        CS_NONE = 2'd0,
        CS_TWO  = 2'd1,
        CS_FOUR = 2'd2
    } cs_mode_t;

    // Data-phase clocks from the split coarse/fine encoding (1..8)
    function automatic logic [3:0] phase_len(input logic [1:0] coarse, input logic fine);
        return {1'b0, coarse, 1'b0} + (fine ? 4'd1 : 4'd2);
    endfunction

endpackage

// File: rtl/hbus_cfg_decode.sv
// Configuration decoder: turns the raw setting fields into data-phase
// lengths, the chip-select arrangement and the total inter-transfer gap.
// Assumes the configuration is static while a transfer is in flight.
module hbus_cfg_decode
    import hbus_pkg::*;
#(
    parameter int GAP_W = 4
) (
    input  logic [1:0]     rd_coarse,
    input  logic           rd_fine,
    input  logic [1:0]     wr_coarse,
    input  logic           wr_fine,
    input  logic           burst,
    input  logic [1:0]     cs_field,
    input  logic           cs_ext,
    input  logic           cs_clk,
    input  logic [GAP_W-1:0] gap,
    output logic           err,
    output logic [3:0]     rd_len,
    output logic [3:0]     wr_len,
    output cs_mode_t       cs_mode,
    output logic [GAP_W:0] gap_total
);
    localparam int GT_W = GAP_W + 1;

    logic wait_nz;

    // Legality check and data-phase lengths (wait settings dropped on error)
    always_comb begin
        wait_nz = |{rd_coarse, rd_fine, wr_coarse, wr_fine};
        err     = burst && wait_nz;
        rd_len  = err ? phase_len(2'd0, 1'b0) : phase_len(rd_coarse, rd_fine);
        wr_len  = err ? phase_len(2'd0, 1'b0) : phase_len(wr_coarse, wr_fine);
    end

    // Pin arrangement from the combined code; unknown codes act as none
    always_comb begin
        case ({cs_ext, cs_field})
            3'b0_11: cs_mode = CS_TWO;
            3'b1_00: cs_mode = CS_FOUR;
            default: cs_mode = CS_NONE;
        endcase
    end

    // Gap plus one clock when per-select clocking meets multiple selects
    always_comb begin
        gap_total = {1'b0, gap} + GT_W'(cs_clk && (cs_mode != CS_NONE));
    end

endmodule

// File: rtl/hbus_seq.sv
// Transfer sequencer: accepts one request, walks address, data and gap
// phases with a shared down-counter, and captures read data.
// Assumes lengths and gap are valid at the acceptance edge.
module hbus_seq
    import hbus_pkg::*;
#(
    parameter int BUS_W = 16,
    parameter int GAP_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [BUS_W-1:0] req_addr,
    input  logic [BUS_W-1:0] req_wdata,
    output logic             req_ready,
    input  logic [3:0]       rd_len,
    input  logic [3:0]       wr_len,
    input  logic [GAP_W:0]   gap_total,
    input  logic             wide,
    input  logic [BUS_W-1:0] bus_in,
    output hb_state_t        state,
    output logic             cur_write,
    output logic [BUS_W-1:0] cur_addr,
    output logic [BUS_W-1:0] cur_wdata,
    output logic             rsp_valid,
    output logic [BUS_W-1:0] rsp_rdata
);
    localparam int GT_W  = GAP_W + 1;
    localparam int CNT_W = (GT_W > 4) ? GT_W : 4;

    logic [3:0]       len_q;
    logic [GAP_W:0]   gap_q;
    logic [CNT_W-1:0] cnt;
    logic [BUS_W-1:0] rd_sample;

    // Width-adjusted read sample
    always_comb begin
        rd_sample = wide ? bus_in : {{(BUS_W-8){1'b0}}, bus_in[7:0]};
    end

    // Phase sequencing, counter and read capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            cur_write <= 1'b0;
            cur_addr  <= '0;
            cur_wdata <= '0;
            len_q     <= 4'd0;
            gap_q     <= '0;
            cnt       <= '0;
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= 1'b0;
            case (state)
                ST_IDLE: if (req_valid) begin
                    cur_write <= req_write;
                    cur_addr  <= req_addr;
                    cur_wdata <= req_wdata;
                    len_q     <= req_write ? wr_len : rd_len;
                    gap_q     <= gap_total;
                    state     <= ST_ADDR;
                end
                ST_ADDR: begin
                    cnt   <= CNT_W'(len_q - 4'd1);
                    state <= ST_DATA;
                end
                ST_DATA: if (cnt == '0) begin
                    if (!cur_write) begin
                        rsp_valid <= 1'b1;
                        rsp_rdata <= rd_sample;
                    end
                    if (gap_q == '0) begin
                        state <= ST_IDLE;
                    end else begin
                        cnt   <= CNT_W'(gap_q - GT_W'(1));
                        state <= ST_GAP;
                    end
                end else begin
                    cnt <= cnt - CNT_W'(1);
                end
                ST_GAP: if (cnt == '0) begin
                    state <= ST_IDLE;
                end else begin
                    cnt <= cnt - CNT_W'(1);
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Ready only when no transfer or gap is pending
    always_comb begin
        req_ready = (state == ST_IDLE);
    end

endmodule

// File: rtl/hbus_pins.sv
// Pin driver: decodes strobes, chip selects and the shared-line value
// from the sequencer phase. Assumes BUS_W >= 9 so a byte lane exists.
module hbus_pins
    import hbus_pkg::*;
#(
    parameter int BUS_W = 16
) (
    input  hb_state_t        state,
    input  logic             cur_write,
    input  logic [BUS_W-1:0] cur_addr,
    input  logic [BUS_W-1:0] cur_wdata,
    input  logic             wide,
    input  cs_mode_t         cs_mode,
    output logic             ale,
    output logic             rd_n,
    output logic             wr_n,
    output logic [3:0]       cs_n,
    output logic [BUS_W-1:0] bus_out,
    output logic             bus_oe
);
    localparam int NCS = 4;

    logic       active;
    logic [1:0] sel;
    logic [2:0] ncs_used;

    // Strobes and shared-line drive per phase
    always_comb begin
        ale    = (state == ST_ADDR);
        rd_n   = !((state == ST_DATA) && !cur_write);
        wr_n   = !((state == ST_DATA) && cur_write);
        bus_oe = (state == ST_ADDR) || ((state == ST_DATA) && cur_write);
        if (state == ST_ADDR)
            bus_out = cur_addr;
        else if ((state == ST_DATA) && cur_write)
            bus_out = wide ? cur_wdata : {{(BUS_W-8){1'b0}}, cur_wdata[7:0]};
        else
            bus_out = '0;
    end

    // Chip-select index and number of lines in use
    always_comb begin
        active = (state == ST_ADDR) || (state == ST_DATA);
        case (cs_mode)
            CS_TWO:  begin sel = {1'b0, cur_addr[BUS_W-1]};  ncs_used = 3'd2; end
            CS_FOUR: begin sel = cur_addr[BUS_W-1 -: 2];     ncs_used = 3'd4; end
            default: begin sel = 2'd0;                       ncs_used = 3'd0; end
        endcase
    end

    for (genvar i = 0; i < NCS; i++) begin : g_cs
        assign cs_n[i] = !(active && (3'(i) < ncs_used) && (sel == 2'(i)));
    end

endmodule

// File: rtl/hbus_mux_master.sv
// Top of the multiplexed host-bus master: ties the configuration decoder,
// the transfer sequencer and the pin driver together.
// Assumes configuration inputs do not change while req_ready is low.
module hbus_mux_master
    import hbus_pkg::*;
#(
    parameter int BUS_W = 16,
    parameter int GAP_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wide,
    input  logic [1:0]       cfg_rd_coarse,
    input  logic             cfg_rd_fine,
    input  logic [1:0]       cfg_wr_coarse,
    input  logic             cfg_wr_fine,
    input  logic             cfg_burst,
    input  logic [1:0]       cfg_cs_field,
    input  logic             cfg_cs_ext,
    input  logic             cfg_cs_clk,
    input  logic [GAP_W-1:0] cfg_gap,
    output logic             cfg_err,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic             req_write,
    input  logic [BUS_W-1:0] req_addr,
    input  logic [BUS_W-1:0] req_wdata,
    output logic             rsp_valid,
    output logic [BUS_W-1:0] rsp_rdata,
    output logic             bus_ale,
    output logic             bus_rd_n,
    output logic             bus_wr_n,
    output logic [3:0]       bus_cs_n,
    output logic [BUS_W-1:0] bus_out,
    output logic             bus_oe,
    input  logic [BUS_W-1:0] bus_in
);
    logic [3:0]       rd_len, wr_len;
    cs_mode_t         cs_mode;
    logic [GAP_W:0]   gap_total;
    hb_state_t        state;
    logic             cur_write;
    logic [BUS_W-1:0] cur_addr, cur_wdata;

    hbus_cfg_decode #(.GAP_W(GAP_W)) u_cfg (
        .rd_coarse (cfg_rd_coarse),
        .rd_fine   (cfg_rd_fine),
        .wr_coarse (cfg_wr_coarse),
        .wr_fine   (cfg_wr_fine),
        .burst     (cfg_burst),
        .cs_field  (cfg_cs_field),
        .cs_ext    (cfg_cs_ext),
        .cs_clk    (cfg_cs_clk),
        .gap       (cfg_gap),
        .err       (cfg_err),
        .rd_len    (rd_len),
        .wr_len    (wr_len),
        .cs_mode   (cs_mode),
        .gap_total (gap_total)
    );

    hbus_seq #(.BUS_W(BUS_W), .GAP_W(GAP_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .req_ready (req_ready),
        .rd_len    (rd_len),
        .wr_len    (wr_len),
        .gap_total (gap_total),
        .wide      (cfg_wide),
        .bus_in    (bus_in),
        .state     (state),
        .cur_write (cur_write),
        .cur_addr  (cur_addr),
        .cur_wdata (cur_wdata),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata)
    );

    hbus_pins #(.BUS_W(BUS_W)) u_pins (
        .state     (state),
        .cur_write (cur_write),
        .cur_addr  (cur_addr),
        .cur_wdata (cur_wdata),
        .wide      (cfg_wide),
        .cs_mode   (cs_mode),
        .ale       (bus_ale),
        .rd_n      (bus_rd_n),
        .wr_n      (bus_wr_n),
        .cs_n      (bus_cs_n),
        .bus_out   (bus_out),
        .bus_oe    (bus_oe)
    );

endmodule

// File: rtl/hbus_mux_master_chk.sv
// Port-level protocol checker for the host-bus master, bound to the top.
// Assumes synchronous active-low reset on rst_n.
module hbus_mux_master_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid,
    input logic       req_ready,
    input logic       rsp_valid,
    input logic       bus_ale,
    input logic       bus_rd_n,
    input logic       bus_wr_n,
    input logic [3:0] bus_cs_n,
    input logic       bus_oe
);
    // R1
    ale_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ale |=> !bus_ale);

    // R1
    ale_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ale |-> $past(req_valid && req_ready));

    // R8
    rsp_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R8
    read_tristate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd_n |-> !bus_oe);

    // R9
    strobes_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!bus_rd_n && !bus_wr_n));

    // R5
    one_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~bus_cs_n) <= 1);

    // R11
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (bus_rd_n && bus_wr_n && !bus_ale && !bus_oe && (bus_cs_n == 4'hF)));

endmodule

bind hbus_mux_master hbus_mux_master_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .bus_ale   (bus_ale),
    .bus_rd_n  (bus_rd_n),
    .bus_wr_n  (bus_wr_n),
    .bus_cs_n  (bus_cs_n),
    .bus_oe    (bus_oe)
);

// File: tb/sim_hbus_mux_master.sv
`timescale 1ns/1ps
module sim_hbus_mux_master;
    localparam int BUS_W = 16;
    localparam int GAP_W = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_wide = 1'b1;
    logic [1:0] cfg_rd_coarse = '0, cfg_wr_coarse = '0, cfg_cs_field = '0;
    logic cfg_rd_fine = 1'b0, cfg_wr_fine = 1'b0, cfg_burst = 1'b0;
    logic cfg_cs_ext = 1'b0, cfg_cs_clk = 1'b0;
    logic [GAP_W-1:0] cfg_gap = '0;
    logic cfg_err;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic req_ready;
    logic [BUS_W-1:0] req_addr = '0, req_wdata = '0;
    logic rsp_valid;
    logic [BUS_W-1:0] rsp_rdata;
    logic bus_ale, bus_rd_n, bus_wr_n, bus_oe;
    logic [3:0] bus_cs_n;
    logic [BUS_W-1:0] bus_out;
    logic [BUS_W-1:0] dev_data = '0;

    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    hbus_mux_master #(.BUS_W(BUS_W), .GAP_W(GAP_W)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_wide(cfg_wide),
        .cfg_rd_coarse(cfg_rd_coarse), .cfg_rd_fine(cfg_rd_fine),
        .cfg_wr_coarse(cfg_wr_coarse), .cfg_wr_fine(cfg_wr_fine),
        .cfg_burst(cfg_burst), .cfg_cs_field(cfg_cs_field), .cfg_cs_ext(cfg_cs_ext),
        .cfg_cs_clk(cfg_cs_clk), .cfg_gap(cfg_gap), .cfg_err(cfg_err),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .bus_ale(bus_ale), .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n),
        .bus_cs_n(bus_cs_n), .bus_out(bus_out), .bus_oe(bus_oe), .bus_in(dev_data)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Expected model functions
    function automatic int exp_err();
        return (cfg_burst && (|{cfg_rd_coarse, cfg_rd_fine, cfg_wr_coarse, cfg_wr_fine})) ? 1 : 0;
    endfunction

    function automatic int exp_len(input bit wr);
        if (exp_err() != 0) return 2;
        if (wr) return 2 * int'(cfg_wr_coarse) + (cfg_wr_fine ? 1 : 2);
        return 2 * int'(cfg_rd_coarse) + (cfg_rd_fine ? 1 : 2);
    endfunction

    function automatic int n_sel();
        if (!cfg_cs_ext && cfg_cs_field == 2'd3) return 2;
        if (cfg_cs_ext && cfg_cs_field == 2'd0) return 4;
        return 0;
    endfunction

    function automatic logic [3:0] exp_cs(input logic [BUS_W-1:0] a);
        if (n_sel() == 2) return ~(4'b0001 << a[15]);
        if (n_sel() == 4) return ~(4'b0001 << a[15:14]);
        return 4'hF;
    endfunction

    function automatic int exp_gap();
        return int'(cfg_gap) + ((cfg_cs_clk && n_sel() != 0) ? 1 : 0);
    endfunction

    function automatic logic [BUS_W-1:0] dev_pat(input logic [BUS_W-1:0] a);
        return a ^ 16'h5A3C;
    endfunction

    function automatic logic [BUS_W-1:0] lane(input logic [BUS_W-1:0] v);
        return cfg_wide ? v : {8'h00, v[7:0]};
    endfunction

    // One full transfer with cycle-by-cycle checks at negative edges
    task automatic xfer(input bit wr, input logic [BUS_W-1:0] a, input logic [BUS_W-1:0] d);
        int n;
        int g;
        logic [3:0] cs_e;
        cs_e = exp_cs(a);
        check(cfg_err == logic'(exp_err()), "R3 cfg_err", cfg_err, exp_err());
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        // address phase
        check(bus_ale == 1'b1, "R1 ale", bus_ale, 1);
        check(bus_oe && bus_out == a, "R1 address drive", bus_out, a);
        check(bus_cs_n == cs_e, "R4 cs in address phase", bus_cs_n, cs_e);
        dev_data = dev_pat(a);
        n = 0;
        @(negedge clk);
        while ((wr ? !bus_wr_n : !bus_rd_n) && n < 20) begin
            n++;
            check(!bus_ale, "R1 ale low in data", bus_ale, 0);
            check(bus_cs_n == cs_e, "R5 cs held in data", bus_cs_n, cs_e);
            if (wr) begin
                check(bus_oe && bus_rd_n && bus_out == lane(d), "R9 R10 write drive", bus_out, lane(d));
            end else begin
                check(!bus_oe, "R8 read tristate", bus_oe, 0);
            end
            @(negedge clk);
        end
        check(n == exp_len(wr), wr ? "R2 R3 write phase length" : "R2 R3 read phase length", n, exp_len(wr));
        check(bus_cs_n == 4'hF, "R5 cs released", bus_cs_n, 4'hF);
        if (wr) begin
            check(!rsp_valid, "R9 no response on write", rsp_valid, 0);
        end else begin
            check(rsp_valid, "R8 response pulse", rsp_valid, 1);
            check(rsp_rdata == lane(dev_pat(a)), "R8 R10 read data", rsp_rdata, lane(dev_pat(a)));
        end
        g = 0;
        while (!req_ready && g < 40) begin
            g++;
            @(negedge clk);
            check(!rsp_valid, "R8 single response", rsp_valid, 0);
        end
        check(g == exp_gap(), "R6 R7 gap", g, exp_gap());
    endtask

    task automatic set_cfg(input bit w, input logic [1:0] rc, input bit rf, input logic [1:0] wc, input bit wf,
                           input bit bu, input logic [1:0] cf, input bit ce, input bit cc, input logic [GAP_W-1:0] gp);
        cfg_wide = w; cfg_rd_coarse = rc; cfg_rd_fine = rf; cfg_wr_coarse = wc; cfg_wr_fine = wf;
        cfg_burst = bu; cfg_cs_field = cf; cfg_cs_ext = ce; cfg_cs_clk = cc; cfg_gap = gp;
        @(negedge clk);
    endtask

    initial begin
        #(5.0 * 150000);
        check(1'b0, "watchdog", 0, 1);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        check(req_ready && !rsp_valid, "R11 ready after reset", req_ready, 1);
        check(!bus_ale && bus_rd_n && bus_wr_n && !bus_oe, "R11 quiet pins", {bus_ale, bus_rd_n, bus_wr_n, bus_oe}, 4'b0110);
        check(bus_cs_n == 4'hF, "R11 cs high", bus_cs_n, 4'hF);

        // R2 shortest and longest phases, no chip select
        set_cfg(1, 2'd0, 1, 2'd3, 0, 0, 2'd0, 0, 0, 4'd0);
        xfer(1'b1, 16'h1234, 16'hBEEF);
        xfer(1'b0, 16'h0F0F, 16'h0);
        set_cfg(1, 2'd3, 0, 2'd0, 1, 0, 2'd0, 0, 0, 4'd2);
        xfer(1'b0, 16'h8001, 16'h0);
        xfer(1'b1, 16'h7FFE, 16'hA5A5);

        // R4 four selects, each address quadrant
        set_cfg(1, 2'd1, 1, 2'd1, 0, 0, 2'd0, 1, 0, 4'd1);
        for (int q = 0; q < 4; q++) xfer(q[0], {q[1:0], 14'h0155}, 16'h6789);

        // R4 two selects, both halves
        set_cfg(1, 2'd0, 0, 2'd0, 0, 0, 2'd3, 0, 0, 4'd0);
        xfer(1'b0, 16'h4000, 16'h0);
        xfer(1'b0, 16'hC000, 16'h0);

        // R4 unknown code acts as none
        set_cfg(1, 2'd0, 0, 2'd0, 0, 0, 2'd1, 0, 0, 4'd0);
        xfer(1'b0, 16'hC000, 16'h0);

        // R3 illegal burst mix, then legal burst
        set_cfg(1, 2'd3, 1, 2'd2, 0, 1, 2'd0, 0, 0, 4'd0);
        check(cfg_err == 1'b1, "R3 err raised", cfg_err, 1);
        xfer(1'b0, 16'h2222, 16'h0);
        xfer(1'b1, 16'h3333, 16'h4444);
        set_cfg(1, 2'd0, 0, 2'd0, 0, 1, 2'd0, 0, 0, 4'd0);
        check(cfg_err == 1'b0, "R3 err clear", cfg_err, 0);

        // R7 extra gap only with multiple selects
        set_cfg(1, 2'd0, 1, 2'd0, 1, 0, 2'd3, 0, 1, 4'd3);
        xfer(1'b1, 16'h8000, 16'h1111);
        set_cfg(1, 2'd0, 1, 2'd0, 1, 0, 2'd0, 0, 1, 4'd3);
        xfer(1'b1, 16'h8000, 16'h1111);
        set_cfg(1, 2'd0, 1, 2'd0, 1, 0, 2'd0, 1, 1, 4'd15);
        xfer(1'b0, 16'hFFFF, 16'h0);

        // R10 byte lane
        set_cfg(0, 2'd1, 0, 2'd1, 1, 0, 2'd0, 1, 0, 4'd1);
        xfer(1'b1, 16'hABCD, 16'hFEDC);
        xfer(1'b0, 16'h9876, 16'h0);

        // Random mix
        for (int k = 0; k < 60; k++) begin
            logic [2:0] code;
            code = 3'($urandom_range(0, 3));
            set_cfg(1'($urandom), 2'($urandom), 1'($urandom), 2'($urandom), 1'($urandom),
                    ($urandom_range(0, 7) == 0), (code == 3'd1) ? 2'd3 : (code == 3'd3 ? 2'd2 : 2'd0),
                    (code == 3'd2), 1'($urandom), 4'($urandom));
            xfer(1'($urandom), 16'($urandom), 16'($urandom));
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule